// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Idle-Grant Revocation

This block decides which of several bus masters may own a shared, multiplexed bus next. Every master has its own request line and grant line, both active low. The arbiter watches two bus-level strobes. One is the cycle frame strobe, which marks that a transaction is running. The other is the initiator-ready strobe, which stays low through the final data phase. The arbiter picks and grants the next owner while the current owner's transfer is still running, so that arbitration costs no bus cycles.

Every access needs its own arbitration. When the granted master starts a transaction, shown by a falling edge of the frame strobe, its grant is withdrawn at once. A burst is one access, so it costs one arbitration. A master that keeps its grant through 16 idle bus clocks without starting loses the grant. That master then gets a one-cycle timeout pulse on its own bit, and it sits out the next arbitration round. The priority rotates: the search starts at the master after the one granted last.

All ports are plain control levels. No data flows through the block, so it has no valid/ready handshake.

Top module: `bus_arbiter_rr`

## Requirements
- R1: While `rst_n` is low, every bit of `gnt_n` is 1 and every bit of `tmo_pulse` is 0, starting immediately (asynchronous reset). After reset, master 0 has the highest priority.
- R2: A grant is issued only to a master whose `req_n` bit was 0 at the clock edge that issues it. When no request is present, `gnt_n` stays all ones. When the arbiter holds no grant and an eligible request is present, the grant line (`gnt_n[i]` = 0) appears right after the next rising edge.
- R3: At most one bit of `gnt_n` is 0 at any time.
- R4: The search order is round-robin. It starts at the index after the master granted last and wraps from N-1 to 0.
- R5: A falling edge of `frame_n` while a grant is held is a transaction start. It is sampled as `frame_n` = 0 at an edge after `frame_n` = 1 at the previous edge. All grants go high after that edge. Any change of grant owner passes through at least one cycle with `gnt_n` all ones.
- R6: A new grant is issued whatever the state of `frame_n` and `irdy_n`. A grant can therefore be given while another master's transfer is in progress.
- R7: A grant is withdrawn after 16 clock edges where the bus is idle (`frame_n` = 1 and `irdy_n` = 1) and no start occurs. Edges where the bus is busy do not count. The edge that withdraws the grant also sets `tmo_pulse[i]` = 1 for exactly one cycle, where i is the master that lost the grant.
- R8: A master that timed out is not eligible in the next arbitration cycle. If it is the only requester, its grant comes one cycle later than it otherwise would.
- R9: If the granted master sets its `req_n` bit to 1 before it starts a transaction, the grant is withdrawn after that edge.
- R10: A falling edge of `frame_n` while no grant is held is ignored. It does not consume the grant issued at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | N | Per-master bus request, active low |
| frame_n | input | 1 | Shared cycle frame strobe, low while a transaction runs |
| irdy_n | input | 1 | Shared initiator-ready strobe, low during data phases |
| gnt_n | output | N | Per-master bus grant, active low |
| tmo_pulse | output | N | One-cycle pulse on the bit of the master whose grant expired |

## Verification
A wrong pointer or wrong owner register shows at `gnt_n` right after the next arbitration edge: the wrong bit goes low, or two bits go low. A wrong idle counter shows only at the 16th idle edge. The grant then falls one cycle early or late, or it survives a stretch where the bus is busy, so the bench counts idle edges to each end of the window. A lost skip mark or a bad start detector shows within one or two cycles: a grant comes back too soon, or it is not withdrawn after a frame edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Grant ownership state of the arbiter.
  typedef enum logic {
    ARB_OPEN = 1'b0,   // no grant outstanding, arbitration runs
    ARB_HELD = 1'b1    // one master holds the grant
  } arb_state_e;
endpackage

// File: rtl/arb_bus_mon.sv
// Watches the shared strobes: reports a transaction start (frame falling)
// and whether the bus is idle in the present cycle.
module arb_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start,
  output logic bus_idle
);
  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  assign start    = frame_q & ~frame_n;
  assign bus_idle = frame_n & irdy_n;
endmodule

// File: rtl/arb_rr_pick.sv
// Round-robin selection: first eligible index after 'last', wrapping.
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] win
);
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (!found && elig[c]) begin
        found = 1'b1;
        win   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/arb_grant_timer.sv
// Counts idle clocks of an outstanding grant; flags the last allowed one.
module arb_grant_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bus_arbiter_rr.sv
module bus_arbiter_rr #(
  parameter int N     = 4,
  parameter int LIMIT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  output logic [N-1:0] gnt_n,
  output logic [N-1:0] tmo_pulse
);
  import arb_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  arb_state_e    state;
  logic [IW-1:0] owner;
  logic [IW-1:0] last;
  logic [N-1:0]  skip;
  logic [N-1:0]  tmo_q;

  logic [N-1:0]  req;
  logic [N-1:0]  elig;
  logic [N-1:0]  owner_oh;
  logic          found;
  logic [IW-1:0] win;
  logic          start;
  logic          bus_idle;
  logic          owner_req;
  logic          expire;
  logic          held;

  assign req      = ~req_n;
  assign elig     = req & ~skip;
  assign held     = (state == ARB_HELD);
  assign owner_oh = N'(1) << owner;
  assign owner_req = |(req & owner_oh);

  arb_bus_mon u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .start    (start),
    .bus_idle (bus_idle)
  );

  arb_rr_pick #(.N(N), .IW(IW)) u_pick (
    .elig  (elig),
    .last  (last),
    .found (found),
    .win   (win)
  );

  arb_grant_timer #(.LIMIT(LIMIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!held),
    .run    (held && bus_idle && !start && owner_req),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARB_OPEN;
      owner <= '0;
      last  <= IW'(N - 1);
      skip  <= '0;
      tmo_q <= '0;
    end else begin
      tmo_q <= '0;
      if (!held) begin
        // one round: a skip mark lasts only for this cycle
        skip <= '0;
        if (found) begin
          state <= ARB_HELD;
          owner <= win;
          last  <= win;
        end
      end else if (start || !owner_req) begin
        state <= ARB_OPEN;
      end else if (expire) begin
        state <= ARB_OPEN;
        skip  <= owner_oh;
        tmo_q <= owner_oh;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign gnt_n[g]     = !(held && (owner == IW'(g)));
    assign tmo_pulse[g] = tmo_q[g];
  end
endmodule

// File: rtl/bus_arbiter_rr_chk.sv
module bus_arbiter_rr_chk #(
  parameter int N     = 4,
  parameter int LIMIT = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic         frame_n,
  input logic         irdy_n,
  input logic [N-1:0] gnt_n,
  input logic [N-1:0] tmo_pulse
);
  localparam logic [N-1:0] ONES = '1;

  logic [7:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idle_run <= '0;
    else if (gnt_n == ONES)              idle_run <= '0;
    else if (frame_n && irdy_n && idle_run != 8'hFF)
                                         idle_run <= idle_run + 8'd1;
  end

  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  a_r5_gap_between_owners: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != ONES && $past(gnt_n) != ONES) |-> (gnt_n == $past(gnt_n)));

  a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt_n) == ONES && gnt_n != ONES) |-> ((~gnt_n & ~$past(req_n)) != '0));

  a_r5_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != ONES && $past(frame_n) && !frame_n) |=> (gnt_n == ONES));

  a_r9_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != ONES && ((~gnt_n & req_n) != '0)) |=> (gnt_n == ONES));

  a_r7_tmo_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmo_pulse));

  a_r7_tmo_revokes: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse != '0) |-> (gnt_n == ONES && (~$past(gnt_n)) == tmo_pulse));

  a_r7_idle_window: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run <= 8'(LIMIT)));
endmodule

bind bus_arbiter_rr bus_arbiter_rr_chk #(.N(N), .LIMIT(LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (req_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .gnt_n     (gnt_n),
  .tmo_pulse (tmo_pulse)
);

// File: tb/bus_arbiter_rr_test.sv
`timescale 1ns/1ps
module bus_arbiter_rr_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] gnt_n;
  logic [N-1:0] tmo_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_arbiter_rr #(.N(N), .LIMIT(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .gnt_n(gnt_n), .tmo_pulse(tmo_pulse)
  );

  // {req_n, frame_n, irdy_n, expected gnt_n, expected tmo_pulse}
  localparam logic [13:0] VEC [15] = '{
    14'b1111_1_1_1111_0000,  // no request: no grant (R2)
    14'b1010_1_1_1110_0000,  // m0,m2 ask, m0 first after reset (R4)
    14'b1010_0_1_1111_0000,  // m0 starts: grant drops (R5)
    14'b1011_0_0_1011_0000,  // m2 granted while bus busy (R6)
    14'b1011_0_1_1011_0000,  // busy, no new edge: held
    14'b1011_1_0_1011_0000,  // last data phase: held
    14'b1011_1_1_1011_0000,  // idle: held
    14'b1011_0_1_1111_0000,  // m2 starts (R5)
    14'b1111_0_0_1111_0000,  // nobody asks (R2)
    14'b0110_1_1_0111_0000,  // m0,m3 ask, m3 follows m2 (R4)
    14'b0110_0_1_1111_0000,  // m3 starts (R5)
    14'b0110_0_0_1110_0000,  // wrap to m0, bus busy (R4, R6)
    14'b0111_0_0_1111_0000,  // m0 drops request (R9)
    14'b0111_1_1_0111_0000,  // m3 again after m0 (R4)
    14'b1111_1_1_1111_0000   // m3 drops (R9)
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic f, input logic i);
    @(negedge clk);
    req_n = r; frame_n = f; irdy_n = i;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset gnt_n", gnt_n, 4'b1111);
    check("R1 reset tmo_pulse", tmo_pulse, 4'b0000);
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[k]) begin
      step(VEC[k][13:10], VEC[k][9], VEC[k][8]);
      check($sformatf("R2,R4,R5,R6,R9 row %0d gnt_n", k), gnt_n, VEC[k][7:4]);
      check($sformatf("R7 row %0d tmo_pulse", k), tmo_pulse, VEC[k][3:0]);
    end

    // R7: idle grant expires on the 16th idle edge
    step(4'b1101, 1'b1, 1'b1);
    check("R7 m1 granted", gnt_n, 4'b1101);
    for (int k = 1; k <= 15; k++) step(4'b1101, 1'b1, 1'b1);
    check("R7 held after 15 idle edges", gnt_n, 4'b1101);
    check("R7 no pulse before expiry", tmo_pulse, 4'b0000);
    step(4'b1101, 1'b1, 1'b1);
    check("R7 grant revoked", gnt_n, 4'b1111);
    check("R7 pulse on m1", tmo_pulse, 4'b0010);
    // R8: skipped one round when alone
    step(4'b1101, 1'b1, 1'b1);
    check("R8 skipped round gnt_n", gnt_n, 4'b1111);
    check("R7 pulse lasts one cycle", tmo_pulse, 4'b0000);
    step(4'b1101, 1'b1, 1'b1);
    check("R8 granted after skip", gnt_n, 4'b1101);

    // R7: busy cycles do not count
    for (int k = 0; k < 20; k++) step(4'b1101, 1'b1, 1'b0);
    check("R7 held through busy bus", gnt_n, 4'b1101);
    for (int k = 0; k < 15; k++) step(4'b1101, 1'b1, 1'b1);
    check("R7 held after 15 idle edges post-busy", gnt_n, 4'b1101);
    step(4'b1101, 1'b1, 1'b1);
    check("R7 revoked on 16th idle edge", gnt_n, 4'b1111);
    check("R7 second pulse on m1", tmo_pulse, 4'b0010);
    step(4'b1111, 1'b1, 1'b1);
    check("R2 no request after timeout", gnt_n, 4'b1111);

    // R10: frame edge with no grant held is ignored
    step(4'b1011, 1'b0, 1'b1);
    check("R10 grant issued on ignored edge", gnt_n, 4'b1011);
    step(4'b1011, 1'b0, 1'b1);
    check("R10 grant not consumed", gnt_n, 4'b1011);
    step(4'b1011, 1'b1, 1'b1);
    step(4'b1011, 1'b0, 1'b1);
    check("R5 start releases m2", gnt_n, 4'b1111);

    // R1: asynchronous reset mid-grant, priority restarts at m0
    step(4'b0110, 1'b1, 1'b1);
    check("R4 m3 follows m2", gnt_n, 4'b0111);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async reset clears grant", gnt_n, 4'b1111);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 pointer reset gives m0", gnt_n, 4'b1110);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule